// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two unsigned operands and a carry-in with no clock and no state. The operand width is split into equal slices. Inside each slice, every bit forms its own generate term (both operand bits high) and propagate term (the operand bits differ). Each internal carry is written out directly as a sum of products of those terms and the slice's carry-in. No internal carry is built from another computed carry.

Each slice reports two signals to a second lookahead stage: a slice propagate (every bit of the slice propagates) and a slice generate (the slice produces a carry by itself). The second stage applies the same expanded equations to the slice-level pairs. It returns the carry into every slice except the lowest, and it forms the final carry-out. The default build has four slices of four bits, which gives a 16-bit adder.

Top module: `cla_adder16`

## Requirements
- R1: `sumOut` equals the low 16 bits of the arithmetic sum `opA + opB + carryIn` for every input combination.
- R2: `carryOut` equals bit 16 of the 17-bit arithmetic sum `opA + opB + carryIn`.
- R3: The carry entering bit 4, bit 8 and bit 12 equals the carry out of the addition of the bits below that position together with `carryIn`. This is seen at `sumOut[4]`, `sumOut[8]` and `sumOut[12]`.
- R4: When every bit position propagates (`opA ^ opB` is all ones), `carryIn` passes through all four slices. With `carryIn` = 1 the result is `sumOut` = 0x0000 and `carryOut` = 1. With `carryIn` = 0 the result is `sumOut` = 0xFFFF and `carryOut` = 0.
- R5: A carry generated in bit 0 crosses three fully propagating slices: 0xFFFF + 0x0001 with `carryIn` = 0 gives `sumOut` = 0x0000 and `carryOut` = 1.
- R6: A carry generated in the top bit of each slice lands in the lowest bit of the next slice: 0x8888 + 0x8888 with `carryIn` = 0 gives `sumOut` = 0x1110 and `carryOut` = 1.
- R7: The outputs follow the current inputs alone. A vector applied after any other vector gives the same result as when it is applied after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First addend |
| opB | input | 16 | Second addend |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | 16 | Low bits of the sum |
| carryOut | output | 1 | Carry out of the top bit |

## Verification
The bench builds the adder with its default parameters: four slices of four bits each. That shape exercises both lookahead levels at full depth. Each slice uses all four of its expanded carry terms, and the second stage combines all four slice pairs, so a carry can be born in any slice and travel through every combination of propagating slices above it. Directed vectors aim at those carry paths: one passes through every slice, and others are generated at a slice boundary. Seeded pseudo-random vectors then cover the remaining mixes of generate, propagate and kill.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Propagate/generate pair used at both lookahead levels
  typedef struct packed {
    logic prop;
    logic gen;
  } pgPair_t;
endpackage

// File: rtl/cla_lookahead.sv
// Expanded lookahead: each carry is a sum of products of p, g and cin,
// never a function of another computed carry.
module cla_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] p,
  input  logic [N-1:0] g,
  input  logic         cin,
  output logic [N-1:0] carry,   // carry into position 0..N-1
  output cla_pkg::pgPair_t blockPg
);
  logic prodTerm;
  logic accTerm;
  logic gProd;
  logic gAcc;

  always_comb begin
    carry[0] = cin;
    for (int j = 1; j < N; j++) begin
      prodTerm = 1'b1;
      accTerm  = 1'b0;
      for (int k = j - 1; k >= 0; k--) begin
        accTerm  = accTerm | (prodTerm & g[k]);
        prodTerm = prodTerm & p[k];
      end
      carry[j] = accTerm | (prodTerm & cin);
    end
    gProd = 1'b1;
    gAcc  = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      gAcc  = gAcc | (gProd & g[k]);
      gProd = gProd & p[k];
    end
    blockPg.prop = gProd;
    blockPg.gen  = gAcc;
  end
endmodule

// File: rtl/cla_group.sv
// One slice: bit P/G, in-slice lookahead, sum bits, exported slice P/G.
module cla_group #(
  parameter int GROUP_W = 4
) (
  input  logic [GROUP_W-1:0] a,
  input  logic [GROUP_W-1:0] b,
  input  logic               cin,
  output logic [GROUP_W-1:0] sum,
  output cla_pkg::pgPair_t   groupPg
);
  logic [GROUP_W-1:0] bitProp;
  logic [GROUP_W-1:0] bitGen;
  logic [GROUP_W-1:0] bitCarry;

  genvar i;
  generate
    for (i = 0; i < GROUP_W; i++) begin : g_bit
      assign bitProp[i] = a[i] ^ b[i];
      assign bitGen[i]  = a[i] & b[i];
      assign sum[i]     = bitProp[i] ^ bitCarry[i];
    end
  endgenerate

  cla_lookahead #(.N(GROUP_W)) u_look (
    .p(bitProp),
    .g(bitGen),
    .cin(cin),
    .carry(bitCarry),
    .blockPg(groupPg)
  );
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16 #(
  parameter int GROUP_W    = 4,
  parameter int NUM_GROUPS = 4,
  localparam int WIDTH     = GROUP_W * NUM_GROUPS
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  cla_pkg::pgPair_t        groupPg [NUM_GROUPS];
  logic [NUM_GROUPS-1:0]   grpProp;
  logic [NUM_GROUPS-1:0]   grpGen;
  logic [NUM_GROUPS-1:0]   grpCarry;
  cla_pkg::pgPair_t        topPg;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_GROUPS; gi++) begin : g_grp
      cla_group #(.GROUP_W(GROUP_W)) u_grp (
        .a(opA[gi*GROUP_W +: GROUP_W]),
        .b(opB[gi*GROUP_W +: GROUP_W]),
        .cin(grpCarry[gi]),
        .sum(sumOut[gi*GROUP_W +: GROUP_W]),
        .groupPg(groupPg[gi])
      );
      assign grpProp[gi] = groupPg[gi].prop;
      assign grpGen[gi]  = groupPg[gi].gen;
    end
  endgenerate

  // Second level: same expanded equations over slice P/G
  cla_lookahead #(.N(NUM_GROUPS)) u_level2 (
    .p(grpProp),
    .g(grpGen),
    .cin(carryIn),
    .carry(grpCarry),
    .blockPg(topPg)
  );

  assign carryOut = topPg.gen | (topPg.prop & carryIn);
endmodule

// File: rtl/cla_adder16_chk.sv
module cla_adder16_chk #(
  parameter int GROUP_W    = 4,
  parameter int NUM_GROUPS = 4,
  localparam int WIDTH     = GROUP_W * NUM_GROUPS
) (
  input logic [WIDTH-1:0]      opA,
  input logic [WIDTH-1:0]      opB,
  input logic                  carryIn,
  input logic [WIDTH-1:0]      sumOut,
  input logic                  carryOut,
  input logic [NUM_GROUPS-1:0] grpCarry,
  input logic [NUM_GROUPS-1:0] grpProp
);
  logic [WIDTH:0] refSum;
  logic [WIDTH:0] lowSum;
  logic [WIDTH-1:0] lowMask;

  always_comb begin
    refSum = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};
    if (!$isunknown({opA, opB, carryIn})) begin
      a_r1_sum_value: assert (sumOut == refSum[WIDTH-1:0])
        else $error("R1 sum mismatch");
      a_r2_carry_out: assert (carryOut == refSum[WIDTH])
        else $error("R2 carry-out mismatch");
      for (int k = 1; k < NUM_GROUPS; k++) begin
        lowMask = (WIDTH'(1) << (k * GROUP_W)) - WIDTH'(1);
        lowSum = {1'b0, opA & lowMask} + {1'b0, opB & lowMask}
               + {{WIDTH{1'b0}}, carryIn};
        a_r3_group_carry: assert (grpCarry[k] == lowSum[k*GROUP_W])
          else $error("R3 carry into slice %0d wrong", k);
        a_r4_slice_pass: assert (!grpProp[k-1] || grpCarry[k] == grpCarry[k-1])
          else $error("R4 propagating slice %0d did not pass carry", k-1);
      end
    end
  end
endmodule

bind cla_adder16 cla_adder16_chk #(.GROUP_W(GROUP_W), .NUM_GROUPS(NUM_GROUPS)) u_chk (
  .opA(opA),
  .opB(opB),
  .carryIn(carryIn),
  .sumOut(sumOut),
  .carryOut(carryOut),
  .grpCarry(grpCarry),
  .grpProp(grpProp)
);

// File: tb/tb_cla_adder16.sv
module tb_cla_adder16;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [15:0] opA;
  logic [15:0] opB;
  logic        carryIn;
  logic [15:0] sumOut;
  logic        carryOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cla_adder16 dut (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sumOut(sumOut), .carryOut(carryOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c);
    @(negedge clk);
    opA = a; opB = b; carryIn = c;
    #1;
  endtask

  task automatic expectRes(input string req, input logic [15:0] s, input logic co);
    checks++;
    if (sumOut !== s || carryOut !== co) begin
      errors++;
      $display("FAIL %s: got sum=%h cout=%b, expected sum=%h cout=%b",
               req, sumOut, carryOut, s, co);
    end
  endtask

  task automatic checkRef(input string req);
    logic [16:0] r;
    r = {1'b0, opA} + {1'b0, opB} + {16'd0, carryIn};
    expectRes(req, r[15:0], r[16]);
  endtask

  task automatic testZero;   // R1 R2 baseline
    apply(16'h0000, 16'h0000, 1'b0);
    expectRes("R1", 16'h0000, 1'b0);
    apply(16'h0000, 16'h0000, 1'b1);
    expectRes("R2", 16'h0001, 1'b0);
  endtask

  task automatic testFullPropagate;  // R4
    apply(16'hFFFF, 16'h0000, 1'b1);
    expectRes("R4", 16'h0000, 1'b1);
    apply(16'hFFFF, 16'h0000, 1'b0);
    expectRes("R4", 16'hFFFF, 1'b0);
    apply(16'hA5A5, 16'h5A5A, 1'b1);
    expectRes("R4", 16'h0000, 1'b1);
  endtask

  task automatic testLowGenerate;  // R5
    apply(16'hFFFF, 16'h0001, 1'b0);
    expectRes("R5", 16'h0000, 1'b1);
  endtask

  task automatic testBoundaries;  // R6 and R3
    apply(16'h8888, 16'h8888, 1'b0);
    expectRes("R6", 16'h1110, 1'b1);
    apply(16'h000F, 16'h0000, 1'b1);
    expectRes("R3", 16'h0010, 1'b0);
    apply(16'h00FF, 16'h0001, 1'b0);
    expectRes("R3", 16'h0100, 1'b0);
    apply(16'h0FFF, 16'h0000, 1'b1);
    expectRes("R3", 16'h1000, 1'b0);
  endtask

  task automatic testHistory;  // R7
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    expectRes("R7", 16'hFFFF, 1'b1);
    apply(16'h1234, 16'h4321, 1'b0);
    expectRes("R7", 16'h5555, 1'b0);
  endtask

  task automatic testRandom;  // R1 R2
    for (int n = 0; n < 2000; n++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom));
      checkRef((n % 2) ? "R2" : "R1");
    end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    opA = '0; opB = '0; carryIn = 1'b0;
    repeat (2) @(negedge clk);
    testZero();
    testFullPropagate();
    testLowGenerate();
    testBoundaries();
    testHistory();
    testRandom();
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 100000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hang, expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule